// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing controller of a byte-wide nonvolatile memory reached over a two-wire serial bus (I2C). A fast system clock samples the serial clock and data lines through two-flop synchronizers. The controller finds Start and Stop conditions on the synchronized samples and checks the device select byte against a fixed type code and three strap inputs. It then takes a two-byte word address and either stores incoming data bytes or returns stored bytes. The only thing it puts on the bus is an active-high pull-low enable for the data line, which an external open-drain pad turns into the wired-AND bus.

Writes go into the array one byte at a time and walk through the current page, wrapping at its end. Once a Stop closes a transaction that carried data, an internal write timer runs. While it runs the controller ignores the bus entirely, so a master can poll by sending the select byte until it is acknowledged. Reads start at the internal address pointer and continue while the master acknowledges. The pointer wraps over the whole array, and a dummy write with a repeated Start gives a random read. A Start followed by nine clocks, a Start and a Stop returns the controller to idle whatever it was doing.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte is acknowledged (data line pulled low through the ninth clock) only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 picks a read (1) or a write (0).
- R2: A select byte that does not match gets no acknowledge, and the controller pulls the line for nothing else until the next Start.
- R3: A falling data line while the clock is high is a Start and restarts select-byte reception. A rising data line while the clock is high is a Stop and ends the transaction.
- R4: A write sends the select byte, then the high word address byte, then the low word address byte, then data. Each byte is acknowledged and each data byte is stored at the pointer. Word address bits above the array size are ignored.
- R5: During writes only the low log2(PAGE_BYTES) pointer bits advance, so a write past the page end wraps to the start of the same page.
- R6: A repeated Start after the two word address bytes, followed by a read select byte, returns the byte at the loaded address.
- R7: Read bytes go out MSB first. The controller sends the next byte while the master acknowledges, wraps from the last array address to 0, and releases the line after a master no-acknowledge.
- R8: A read that starts with no word address returns the byte one past the last byte written or read.
- R9: A Stop that ends a transaction with at least one stored data byte starts a WRITE_CYCLES-cycle busy period. During it no select byte is acknowledged, and it ends by itself.
- R10: A Start, nine clocks with the data line high, a Start and a Stop leave the controller idle and ready, even if it was in the middle of a byte, with nothing stored.
- R11: `sda_pull_o` is low out of reset, is a pull-low enable only, and changes only after a synchronized clock falling edge or a bus condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Hard-wired device select strap value |
| sda_pull_o | output | 1 | Active-high enable that pulls the data line low |

## Verification
The bench builds the controller with MEM_DEPTH=64, PAGE_BYTES=8 and WRITE_CYCLES=600. With an 8-byte page, the in-page wrap needs only a short burst. With a 64-byte array, a sequential read that crosses from the last address to 0 is cheap to set up. The short write time lets the bench see both the refused poll during the busy period and the accepted one after it, in the same run as the recovery and mismatch cases.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_AHI,
    BY_ALO,
    BY_DATA
  } byte_kind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int AW = 10,
  parameter int PB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_lin,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)           addr <= '0;
    else if (load)     addr <= load_val;
    else if (inc_page) addr <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
    else if (inc_lin)  addr <= addr + 1'b1;
  end

  // R5: stepping inside a page never disturbs the page bits
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inc_page && !load) |=> addr[AW-1:PB] == $past(addr[AW-1:PB]));
endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (kick)     cnt <= CW'(CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0);

  // R9: the busy period only begins from a kick
  assert_busy_from_kick_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(kick));
endmodule

// File: rtl/nv_array.sv
module nv_array #(
  parameter int DEPTH = 1024,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int MEM_DEPTH    = 1024,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  import eeprom_slave_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PB = $clog2(PAGE_BYTES);

  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic busy;
  logic [AW-1:0] cur_addr;
  logic [7:0] rd_data;

  phase_t     phase;
  byte_kind_t kind;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, addr_hi, tx_sr;
  logic is_read, mack, wrote, pull_q;
  logic we_q, ld_q, incp_q, incl_q, kick_q;

  bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  addr_counter #(.AW(AW), .PB(PB)) u_ptr (
    .clk(clk), .rst(rst), .load(ld_q),
    .load_val(AW'({addr_hi, shreg})),
    .inc_page(incp_q), .inc_lin(incl_q), .addr(cur_addr)
  );

  write_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .kick(kick_q), .busy(busy)
  );

  nv_array #(.DEPTH(MEM_DEPTH), .W(8)) u_mem (
    .clk(clk), .we(we_q), .addr(cur_addr), .wdata(shreg), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      kind    <= BY_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      addr_hi <= '0;
      tx_sr   <= '0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      wrote   <= 1'b0;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      ld_q    <= 1'b0;
      incp_q  <= 1'b0;
      incl_q  <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      ld_q   <= 1'b0;
      incp_q <= 1'b0;
      incl_q <= 1'b0;
      kick_q <= 1'b0;
      if (busy) begin
        phase  <= PH_IDLE;
        pull_q <= 1'b0;
      end else if (start_det) begin
        phase   <= PH_RX;
        kind    <= BY_DEV;
        bit_cnt <= '0;
        pull_q  <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        pull_q <= 1'b0;
        if (wrote) begin
          kick_q <= 1'b1;
          wrote  <= 1'b0;
        end
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              case (kind)
                BY_DEV: begin
                  if (shreg[7:4] == DEV_TYPE && shreg[3:1] == strap_i) begin
                    is_read <= shreg[0];
                    pull_q  <= 1'b1;
                    phase   <= PH_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BY_AHI: begin
                  addr_hi <= shreg;
                  pull_q  <= 1'b1;
                  phase   <= PH_ACK;
                end
                BY_ALO: begin
                  ld_q   <= 1'b1;
                  pull_q <= 1'b1;
                  phase  <= PH_ACK;
                end
                default: begin
                  we_q   <= 1'b1;
                  incp_q <= 1'b1;
                  wrote  <= 1'b1;
                  pull_q <= 1'b1;
                  phase  <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (kind == BY_DEV && is_read) begin
                tx_sr   <= rd_data;
                pull_q  <= ~rd_data[7];
                bit_cnt <= 4'd1;
                phase   <= PH_TX;
              end else begin
                pull_q  <= 1'b0;
                bit_cnt <= '0;
                phase   <= PH_RX;
                case (kind)
                  BY_DEV:  kind <= BY_AHI;
                  BY_AHI:  kind <= BY_ALO;
                  default: kind <= BY_DATA;
                endcase
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_cnt != 4'd8) begin
                pull_q  <= ~tx_sr[6];
                tx_sr   <= tx_sr << 1;
                bit_cnt <= bit_cnt + 1'b1;
              end else begin
                pull_q <= 1'b0;
                incl_q <= 1'b1;
                phase  <= PH_MACK;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                tx_sr   <= rd_data;
                pull_q  <= ~rd_data[7];
                bit_cnt <= 4'd1;
                phase   <= PH_TX;
              end else begin
                pull_q <= 1'b0;
                phase  <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R11: the pull enable moves only after a clock fall or a bus condition
  assert_pull_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull_q) |-> $past(scl_fall || start_det || stop_det));

  // R9: the line is never pulled while a write cycle runs
  assert_busy_silent_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pull_q);

  // R3: a Start seen while ready restarts select-byte reception
  assert_start_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (start_det && !busy) |=> (phase == PH_RX && kind == BY_DEV && bit_cnt == 4'd0));

  // R7: a master no-acknowledge releases the line and ends the read
  assert_nack_release_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MACK && scl_fall && !mack && !start_det && !stop_det && !busy)
      |=> (phase == PH_IDLE && !pull_q));
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int DEPTH = 64;
  localparam int PAGE  = 8;
  localparam int WCYC  = 600;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic pull;
  logic bus;
  assign bus = m_sda & ~pull;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus), .strap_i(strap), .sda_pull_o(pull)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  logic [7:0] ref_mem [DEPTH];

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  // monitor: pairs each observed result with the expectation queued for it
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      item_t e, o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      checks++;
      if (e.val != o.val) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", e.tag, o.val, e.val);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    seen = bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
    logic s;
    item_t it;
    it.tag = tag; it.val = exp_ack; exp_q.push_back(it);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    it.val = s ? 0 : 1; obs_q.push_back(it);
  endtask

  task automatic recv_byte(input int exp_val, input bit give_ack, input string tag);
    logic s;
    logic [7:0] v;
    item_t it;
    it.tag = tag; it.val = exp_val; exp_q.push_back(it);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(give_ack ? 1'b0 : 1'b1, s);
    it.val = int'(v); obs_q.push_back(it);
  endtask

  task automatic write_seq(input int a, input int n, input int base, input string tag);
    bus_start();
    send_byte(DEV_W, 1, {tag, " select ack R1"});
    send_byte(8'h00, 1, {tag, " addr hi ack R4"});
    send_byte(8'(a), 1, {tag, " addr lo ack R4"});
    for (int i = 0; i < n; i++) begin
      int d, slot;
      d = (base + i * 7) & 8'hFF;
      slot = (a & ~(PAGE - 1)) | ((a + i) & (PAGE - 1));
      ref_mem[slot] = 8'(d);
      send_byte(8'(d), 1, {tag, " data ack R4"});
    end
    bus_stop();
  endtask

  task automatic read_seq(input int a, input int n, input string tag);
    bus_start();
    send_byte(DEV_W, 1, {tag, " dummy select R6"});
    send_byte(8'h00, 1, {tag, " dummy hi R6"});
    send_byte(8'(a), 1, {tag, " dummy lo R6"});
    bus_start();
    send_byte(DEV_R, 1, {tag, " read select R3"});
    for (int i = 0; i < n; i++)
      recv_byte(int'(ref_mem[(a + i) % DEPTH]), i < n - 1, tag);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic s;
    wq(5);
    rst = 1'b0;
    wq(5);
    checks++;
    if (pull !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset pull actual=%0b expected=0", pull);
    end

    // byte write, then poll during and after the write cycle
    write_seq(5, 1, 8'h3C, "R4 byte write");
    bus_start();
    send_byte(DEV_W, 0, "R9 poll while busy");
    bus_stop();
    wq(WCYC + 20);
    bus_start();
    send_byte(DEV_W, 1, "R9 poll after busy");
    bus_stop();
    wq(20);

    read_seq(5, 1, "R6 random read");

    // page write wrapping inside its page, sequential then current-address read
    write_seq(8'h0C, 8, 8'h40, "R5 page wrap");
    wq(WCYC + 20);
    read_seq(8'h08, 7, "R7 sequential");
    bus_start();
    send_byte(DEV_R, 1, "R8 current select");
    recv_byte(int'(ref_mem[15]), 1'b0, "R8 current address");
    bus_stop();

    // mismatches: wrong strap, wrong type code
    bus_start();
    send_byte(8'hA2, 0, "R2 strap mismatch");
    send_byte(8'h55, 0, "R2 silent after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hBA, 0, "R1 type mismatch");
    bus_stop();

    // array end wrap
    write_seq(8'h3F, 2, 8'h90, "R5 edge page");
    wq(WCYC + 20);
    write_seq(8'h00, 1, 8'h5A, "R4 addr zero");
    wq(WCYC + 20);
    read_seq(8'h3F, 2, "R7 array wrap");
    read_seq(8'h38, 1, "R5 wrapped byte");

    // recovery from the middle of the low address byte
    bus_start();
    send_byte(DEV_W, 1, "R10 pre select");
    send_byte(8'h00, 1, "R10 pre hi");
    clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_start();
    for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
    bus_start();
    bus_stop();
    wq(10);
    read_seq(5, 1, "R10 after recovery");

    wq(20);
    finish_run();
  end
endmodule